// File: doc/BRIEF.md
# Leap-Forward Pseudo-Random Word Generator

This block produces a multi-bit pseudo-random word every clock cycle from a single maximal-length shift-register sequence generator of `WIDTH` bits. A plain generator of this kind yields one new bit per clock, and adjacent bits are strongly correlated. This block instead applies `STEP` iterations of the one-bit recurrence in a single clock. It uses an XOR network derived from the `STEP`-th power of the one-step state-transition matrix over GF(2), and that network is computed while the design elaborates. The newest `STEP` bits of the state then form the output word.

A host resets the generator to a fixed starting state, or loads a seed of its own. It raises the enable input on every cycle in which it wants a fresh word. An all-zero seed would freeze the register, so it is never accepted: a fixed non-zero pattern takes its place. Width and step are parameters. Widths from 2 to 8 are supported, each with its own maximal-length tap set. The step may be any value from 1 up to the width. A step of 1 selects the plain single-shift variant.

Top module: `lfp_leap_gen`

## Requirements
- R1: While `rst_i` is high at a clock edge, the state becomes `RESET_SEED` on that edge, whatever the load and enable inputs are.
- R2: The state holds the last `WIDTH` recurrence bits. Bit `WIDTH-1` is the oldest bit x[n-WIDTH] and bit 0 is the newest x[n-1]. Each new bit is the XOR of x[n-d] for every delay d in the tap set. The tap sets are: width 2 {1,2}, 3 {2,3}, 4 {3,4}, 5 {3,5}, 6 {5,6}, 7 {6,7}, 8 {4,5,6,8}. On an enabled cycle without load or reset, the state moves exactly `STEP` recurrence steps forward.
- R3: `rnd_o` equals the low `STEP` bits of the state, with the earliest produced bit at the MSB. For width 4 and step 4 from state 4'b1000, successive words are 4'b1001, 4'b1010, 4'b1111, 4'b0001. These are consecutive non-overlapping groups of the bit stream 100110101111000, which repeats.
- R4: Under continuous enable, the state first returns to its starting value after (2^WIDTH-1)/gcd(STEP, 2^WIDTH-1) cycles. That is 15 cycles for width 4 with step 4, and 85 cycles for width 8 with step 3.
- R5: With enable, load and reset all low, the state and `rnd_o` hold their values.
- R6: A high `seed_ld_i` with a non-zero `seed_val_i` loads that value into the state on the edge, whether enable is high or low.
- R7: When load and enable are both high in the same cycle, the load wins, and the generator does not advance on that edge.
- R8: Loading an all-zero seed puts a 1 in bit `WIDTH-1` and zeros in every other bit.
- R9: After reset, the state is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| adv_en_i | input | 1 | Advance the generator by STEP steps on this edge |
| seed_ld_i | input | 1 | Load the seed on this edge |
| seed_val_i | input | WIDTH | Seed, with bit WIDTH-1 as the oldest recurrence bit |
| rnd_o | output | STEP | Random word: the newest STEP state bits |

## Verification
Seed load and advance can both be requested on the same edge, and reset can coincide with both. The bench raises load and enable together, both with a non-zero seed and with a zero seed. It judges the result by whether the next word equals the loaded or substituted seed exactly, or equals that value moved one leap forward. It also asserts reset together with load and enable, and expects the reset seed. Two configurations run side by side, width 4 with step 4 and width 8 with step 3. Every non-zero seed is swept, and each result is compared against an arithmetic model of the one-bit recurrence.

// File: rtl/lfp_pkg.sv
package lfp_pkg;

   localparam int MAX_W = 8;

   typedef logic [MAX_W-1:0]            tap_mask_t;
   typedef logic [MAX_W-1:0][MAX_W-1:0] row_set_t;

   // Delay-indexed tap mask: bit d-1 set means x[n-d] feeds the new bit.
   function automatic tap_mask_t lfp_taps(input int m);
      case (m)
         2:       return 8'b0000_0011;
         3:       return 8'b0000_0110;
         4:       return 8'b0000_1100;
         5:       return 8'b0001_0100;
         6:       return 8'b0011_0000;
         7:       return 8'b0110_0000;
         8:       return 8'b1011_1000;
         default: return '0;
      endcase
   endfunction

   // Row j is the set of current state bits whose XOR gives state bit j
   // after k single steps (row j of the transition matrix raised to k).
   function automatic row_set_t lfp_leap_rows(input int m, input int k);
      row_set_t  r;
      tap_mask_t tp;
      tap_mask_t fb;
      tp = lfp_taps(m);
      for (int j = 0; j < MAX_W; j++) begin
         r[j] = (j < m) ? (tap_mask_t'(1) << j) : '0;
      end
      for (int s = 0; s < k; s++) begin
         fb = '0;
         for (int d = 0; d < MAX_W; d++) begin
            if (d < m && tp[d]) fb = fb ^ r[d];
         end
         for (int j = MAX_W - 1; j > 0; j--) begin
            if (j < m) r[j] = r[j-1];
         end
         r[0] = fb;
      end
      return r;
   endfunction

endpackage

// File: rtl/lfp_seed_guard.sv
module lfp_seed_guard #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] seed_i,
   output logic [WIDTH-1:0] safe_o
);
   localparam logic [WIDTH-1:0] ZERO_SUB = {1'b1, {(WIDTH-1){1'b0}}};

   always_comb begin
      safe_o = (seed_i == '0) ? ZERO_SUB : seed_i;
   end
endmodule

// File: rtl/lfp_leap_net.sv
module lfp_leap_net
   import lfp_pkg::*;
#(
   parameter int WIDTH = 4,
   parameter int STEP  = 4
) (
   input  logic [WIDTH-1:0] st_i,
   output logic [WIDTH-1:0] nxt_o
);
   localparam tap_mask_t TAPS = lfp_taps(WIDTH);
   localparam row_set_t  ROWS = lfp_leap_rows(WIDTH, STEP);

   generate
      if (STEP == 1) begin : g_single
         logic fb;
         always_comb begin
            fb    = ^(st_i & TAPS[WIDTH-1:0]);
            nxt_o = {st_i[WIDTH-2:0], fb};
         end
      end else begin : g_leap
         for (genvar j = 0; j < WIDTH; j++) begin : g_bit
            always_comb begin
               nxt_o[j] = ^(st_i & ROWS[j][WIDTH-1:0]);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/lfp_leap_gen.sv
module lfp_leap_gen #(
   parameter int               WIDTH      = 4,
   parameter int               STEP       = 4,
   parameter logic [WIDTH-1:0] RESET_SEED = {1'b1, {(WIDTH-1){1'b0}}}
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             adv_en_i,
   input  logic             seed_ld_i,
   input  logic [WIDTH-1:0] seed_val_i,
   output logic [STEP-1:0]  rnd_o
);
   generate
      if (WIDTH < 2 || WIDTH > lfp_pkg::MAX_W) begin : g_bad_width
         $error("lfp_leap_gen: WIDTH must lie in 2..8");
      end
      if (STEP < 1 || STEP > WIDTH) begin : g_bad_step
         $error("lfp_leap_gen: STEP must lie in 1..WIDTH");
      end
      if (RESET_SEED == '0) begin : g_bad_seed
         $error("lfp_leap_gen: RESET_SEED must be non-zero");
      end
   endgenerate

   logic [WIDTH-1:0] st_q;
   logic [WIDTH-1:0] st_nxt;
   logic [WIDTH-1:0] seed_safe;

   lfp_seed_guard #(.WIDTH(WIDTH)) guard_i (
      .seed_i (seed_val_i),
      .safe_o (seed_safe)
   );

   lfp_leap_net #(.WIDTH(WIDTH), .STEP(STEP)) net_i (
      .st_i  (st_q),
      .nxt_o (st_nxt)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i)          st_q <= RESET_SEED;
      else if (seed_ld_i) st_q <= seed_safe;
      else if (adv_en_i)  st_q <= st_nxt;
   end

   assign rnd_o = st_q[STEP-1:0];
endmodule

// File: rtl/lfp_leap_gen_chk.sv
module lfp_leap_gen_chk #(
   parameter int               WIDTH      = 4,
   parameter int               STEP       = 4,
   parameter logic [WIDTH-1:0] RESET_SEED = {1'b1, {(WIDTH-1){1'b0}}}
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             adv_en_i,
   input logic             seed_ld_i,
   input logic [WIDTH-1:0] seed_val_i,
   input logic [WIDTH-1:0] st_i
);
   localparam logic [WIDTH-1:0] ZERO_SUB = {1'b1, {(WIDTH-1){1'b0}}};

   // R1
   reset_seed_chk: assert property (@(posedge clk_i)
      rst_i |=> st_i == RESET_SEED);

   // R5
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !seed_ld_i && !adv_en_i |=> $stable(st_i));

   // R6
   seed_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      seed_ld_i && seed_val_i != '0 |=> st_i == $past(seed_val_i));

   // R7
   load_beats_adv_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      seed_ld_i && adv_en_i && seed_val_i != '0 |=> st_i == $past(seed_val_i));

   // R8
   zero_sub_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      seed_ld_i && seed_val_i == '0 |=> st_i == ZERO_SUB);

   // R9
   never_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      st_i != '0);

   generate
      if (STEP < WIDTH) begin : g_shift
         // R2
         leap_shift_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            adv_en_i && !seed_ld_i |=> st_i[WIDTH-1:STEP] == $past(st_i[WIDTH-1-STEP:0]));
      end
   endgenerate
endmodule

bind lfp_leap_gen lfp_leap_gen_chk #(
   .WIDTH      (WIDTH),
   .STEP       (STEP),
   .RESET_SEED (RESET_SEED)
) chk_i (
   .clk_i      (clk_i),
   .rst_i      (rst_i),
   .adv_en_i   (adv_en_i),
   .seed_ld_i  (seed_ld_i),
   .seed_val_i (seed_val_i),
   .st_i       (st_q)
);

// File: tb/lfp_leap_gen_tb_top.sv
`timescale 1ns/1ps
module lfp_leap_gen_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en  = 1'b0;
   logic       ld  = 1'b0;
   logic [3:0] seed_a = '0;
   logic [7:0] seed_b = '0;
   logic [3:0] rnd_a;
   logic [2:0] rnd_b;

   int n_cmp  = 0;
   int n_bad  = 0;
   bit done   = 1'b0;
   logic [7:0] ma, mb;

   always #10 clk = ~clk;

   lfp_leap_gen #(.WIDTH(4), .STEP(4), .RESET_SEED(4'b1000)) dut_i (
      .clk_i(clk), .rst_i(rst), .adv_en_i(en), .seed_ld_i(ld),
      .seed_val_i(seed_a), .rnd_o(rnd_a));

   lfp_leap_gen #(.WIDTH(8), .STEP(3), .RESET_SEED(8'b1000_0000)) dut_b_i (
      .clk_i(clk), .rst_i(rst), .adv_en_i(en), .seed_ld_i(ld),
      .seed_val_i(seed_b), .rnd_o(rnd_b));

   function automatic logic [7:0] mstep(logic [7:0] s, int m, logic [7:0] tp, int k);
      logic [7:0] r = s;
      logic [7:0] mask = (8'd1 << m) - 8'd1;
      for (int i = 0; i < k; i++) r = ((r << 1) | {7'b0, ^(r & tp)}) & mask;
      return r;
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // one clock: model follows the requirements, then sample at negedge
   task automatic cyc();
      @(posedge clk);
      if (rst) begin
         ma = 8'b1000; mb = 8'b1000_0000;
      end else if (ld) begin
         ma = (seed_a == 0) ? 8'b1000 : {4'b0, seed_a};
         mb = (seed_b == 0) ? 8'b1000_0000 : seed_b;
      end else if (en) begin
         ma = mstep(ma, 4, 8'h0C, 4);
         mb = mstep(mb, 8, 8'hB8, 3);
      end
      @(negedge clk);
   endtask

   task automatic cmp_models(string tag);
      chk(tag, {4'b0, rnd_a}, {4'b0, ma[3:0]});
      chk(tag, {5'b0, rnd_b}, {5'b0, mb[2:0]});
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      logic [3:0] w [3];
      logic [2:0] wb [3];
      int cnt;
      @(negedge clk);
      cyc(); cyc();
      rst = 1'b0;
      // R1 reset state
      chk("R1", {4'b0, rnd_a}, 8'h08);
      chk("R1", {5'b0, rnd_b}, 8'h00);

      // R3 known words from 1000
      en = 1'b1;
      w = '{4'b1001, 4'b1010, 4'b1111};
      for (int i = 0; i < 3; i++) begin cyc(); chk("R3", {4'b0, rnd_a}, {4'b0, w[i]}); end
      cyc(); chk("R3", {4'b0, rnd_a}, 8'h01);
      cmp_models("R2");

      // R4 period 15 for width 4 step 4
      ld = 1'b1; seed_a = 4'b1000; cyc(); ld = 1'b0;
      cnt = 0;
      do begin cyc(); cnt++; end while (rnd_a != 4'b1000 && cnt < 40);
      chk("R4", 8'(cnt), 8'd15);

      // R4 period 85 for width 8 step 3, plus per-cycle model compare
      ld = 1'b1; seed_b = 8'h5A; cyc(); ld = 1'b0;
      for (int i = 0; i < 3; i++) begin cyc(); wb[i] = rnd_b; end
      for (int i = 3; i < 85; i++) begin cyc(); cmp_models("R2"); end
      for (int i = 0; i < 3; i++) begin cyc(); chk("R4", {5'b0, rnd_b}, {5'b0, wb[i]}); end

      // R5 hold with everything low
      en = 1'b0;
      w[0] = rnd_a; wb[0] = rnd_b;
      for (int i = 0; i < 5; i++) begin
         cyc();
         chk("R5", {4'b0, rnd_a}, {4'b0, w[0]});
         chk("R5", {5'b0, rnd_b}, {5'b0, wb[0]});
      end

      // R6 load with enable low
      ld = 1'b1; seed_a = 4'b0110; seed_b = 8'h33; cyc(); ld = 1'b0;
      chk("R6", {4'b0, rnd_a}, 8'h06);
      chk("R6", {5'b0, rnd_b}, 8'h03);

      // R7 load and enable together: load wins, no advance
      en = 1'b1; ld = 1'b1; seed_a = 4'b1011; seed_b = 8'h01; cyc(); ld = 1'b0;
      chk("R7", {4'b0, rnd_a}, 8'h0B);
      chk("R7", {5'b0, rnd_b}, 8'h01);
      cyc(); cmp_models("R2");

      // R8 zero seed substituted, with enable high too; R9 stays non-zero
      ld = 1'b1; seed_a = 4'b0000; seed_b = 8'h00; cyc(); ld = 1'b0;
      chk("R8", {4'b0, rnd_a}, 8'h08);
      chk("R8", {5'b0, rnd_b}, 8'h00);
      for (int i = 0; i < 20; i++) begin
         cyc();
         chk("R9", {7'b0, rnd_a != 4'b0}, 8'h01);
         cmp_models("R2");
      end

      // R2 exhaustive seed sweep, width 4 step 4
      for (int s = 1; s < 16; s++) begin
         ld = 1'b1; seed_a = 4'(s); cyc(); ld = 1'b0;
         cyc();
         chk("R2", {4'b0, rnd_a}, mstep(8'(s), 4, 8'h0C, 4));
      end

      // R2 exhaustive seed sweep, width 8 step 3 (three words cover the state)
      for (int s = 1; s < 256; s++) begin
         ld = 1'b1; seed_b = 8'(s); cyc(); ld = 1'b0;
         for (int i = 1; i <= 3; i++) begin
            cyc();
            chk("R2", {5'b0, rnd_b}, {5'b0, mstep(8'(s), 8, 8'hB8, 3 * i) & 8'h07});
         end
      end

      // R1 reset beats load and enable
      rst = 1'b1; ld = 1'b1; en = 1'b1; seed_a = 4'b0101; seed_b = 8'h77; cyc();
      rst = 1'b0; ld = 1'b0; en = 1'b0;
      chk("R1", {4'b0, rnd_a}, 8'h08);
      chk("R1", {5'b0, rnd_b}, 8'h00);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule